// File: doc/BRIEF.md
# Compressed Frame Prefix and Stream Splicer

This block turns the two separately produced byte streams of one compressed video frame into a single contiguous byte stream. One stream is the first (mode and probability) partition, the other is the coefficient payload. A start pulse captures both lengths, a key-frame flag, the picture width and height, and the capacity of the destination buffer. The block then checks that the finished frame fits in the buffer and that the first-partition length can be encoded. If either check fails, it raises an error pulse and sends nothing.

When the frame is accepted, the block sends a packed 3-byte frame tag. On a key frame a start code and the picture dimensions follow the tag. The first-partition bytes come next and the payload bytes last, with no filler between the sections. Output is byte-wide with valid/ready and a last marker. A done pulse carries the total byte count.

Top module: `vp8_frame_asm`

## Requirements
- R1: The frame tag is the 24-bit value (first_len << 5) | 0x10 | inter, where inter is 0 on a key frame and 1 otherwise. It is sent as the first three output bytes, bits 7:0 first.
- R2: On a key frame the prefix is 10 bytes: the 3 tag bytes, then 0x9D, 0x01, 0x2A, then the width low byte, width high byte, height low byte and height high byte.
- R3: On an inter frame the prefix is only the 3 tag bytes.
- R4: After the prefix come all first-partition bytes in arrival order, then all payload bytes in arrival order. No other bytes are inserted.
- R5: If capacity < first_len + payload_len + prefix_len, `err` pulses for one cycle two cycles after the start pulse. In that case no output byte is sent, no input byte is accepted and no done pulse occurs. A capacity equal to the total is accepted.
- R6: `done` pulses for one cycle, in the cycle after the last output byte is accepted. `done_size` then holds first_len + payload_len + prefix_len.
- R7: `out_last` is high only on the final byte of the frame. That is the final payload byte; if the payload length is zero it is the final first-partition byte; if both lengths are zero it is the final prefix byte.
- R8: A start pulse while a frame is in progress has no effect on the frame's bytes, its size or its timing.
- R9: `hdr_ready` is high only while first-partition bytes are being forwarded and `pay_ready` only while payload bytes are being forwarded. The two are never high together, and neither is high when the block is idle.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values. No byte is lost or repeated under any backpressure pattern.
- R11: A first-partition length of 2^19 or more does not fit the tag field. It is rejected with the same error behaviour as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame; captures the fields below |
| key_frame | input | 1 | 1 for a key frame |
| hdr_len | input | LEN_W | First-partition length in bytes |
| pay_len | input | LEN_W | Payload length in bytes |
| pic_w | input | 16 | Picture width |
| pic_h | input | 16 | Picture height |
| capacity | input | LEN_W+2 | Destination buffer size in bytes |
| hdr_data | input | 8 | First-partition byte |
| hdr_valid | input | 1 | First-partition byte valid |
| hdr_ready | output | 1 | First-partition byte accepted |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte valid |
| pay_ready | output | 1 | Payload byte accepted |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_last | output | 1 | Final byte of the frame |
| done | output | 1 | One-cycle completion pulse |
| done_size | output | LEN_W+2 | Total frame size in bytes |
| err | output | 1 | One-cycle rejection pulse |

## Verification
The hardest case to reach from the ports is a section boundary that coincides with a stall. This happens when the final byte of a section is held in the output register while the next section's source is already presenting data. It also happens when an empty section has to be skipped in the same cycle. The bench sweeps every combination of small first-partition and payload lengths, including zero, for both frame kinds. It runs each combination once with free flow and once with pseudo-random stalls on both the output ready and the input valids, so these boundary stalls occur many times. A second start is pushed into every accepted frame just after it begins, and capacities one byte below the total exercise the rejection path.

// File: rtl/vp8_asm_pkg.sv
package vp8_asm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_PREFIX,
    ST_HDR,
    ST_PAY,
    ST_DRAIN
  } asm_state_t;

  localparam int TAG_LEN_W   = 19;
  localparam int DIM_W       = 16;
  localparam int PIDX_W      = 4;
  localparam int PFX_KEY     = 10;
  localparam int PFX_INTER   = 3;
  localparam logic [7:0] SYNC_B0 = 8'h9D;
  localparam logic [7:0] SYNC_B1 = 8'h01;
  localparam logic [7:0] SYNC_B2 = 8'h2A;
endpackage

// File: rtl/vp8_prefix_gen.sv
module vp8_prefix_gen
  import vp8_asm_pkg::*;
(
  input  logic [TAG_LEN_W-1:0] first_len,
  input  logic                 key,
  input  logic [DIM_W-1:0]     width,
  input  logic [DIM_W-1:0]     height,
  input  logic [PIDX_W-1:0]    idx,
  output logic [7:0]           pfx_byte,
  output logic [PIDX_W-1:0]    pfx_len
);
  localparam int TAG_W = TAG_LEN_W + 5;

  logic [TAG_W-1:0] tag;

  // length in the top bits, bit 4 always set, bit 0 flags an inter frame
  assign tag     = {first_len, 1'b1, 3'b000, ~key};
  assign pfx_len = key ? PIDX_W'(PFX_KEY) : PIDX_W'(PFX_INTER);

  always_comb begin
    case (idx)
      4'd0:    pfx_byte = tag[7:0];
      4'd1:    pfx_byte = tag[15:8];
      4'd2:    pfx_byte = tag[23:16];
      4'd3:    pfx_byte = SYNC_B0;
      4'd4:    pfx_byte = SYNC_B1;
      4'd5:    pfx_byte = SYNC_B2;
      4'd6:    pfx_byte = width[7:0];
      4'd7:    pfx_byte = width[15:8];
      4'd8:    pfx_byte = height[7:0];
      4'd9:    pfx_byte = height[15:8];
      default: pfx_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/vp8_size_check.sv
module vp8_size_check
  import vp8_asm_pkg::*;
#(
  parameter int LEN_W = 24,
  localparam int CAP_W = LEN_W + 2
) (
  input  logic [LEN_W-1:0]  first_len,
  input  logic [LEN_W-1:0]  body_len,
  input  logic [PIDX_W-1:0] pfx_len,
  input  logic [CAP_W-1:0]  capacity,
  output logic [CAP_W-1:0]  total,
  output logic              reject
);
  logic too_long;

  assign total = CAP_W'(first_len) + CAP_W'(body_len) + CAP_W'(pfx_len);

  generate
    if (LEN_W > TAG_LEN_W) begin : g_len_guard
      assign too_long = |first_len[LEN_W-1:TAG_LEN_W];
    end else begin : g_len_fits
      assign too_long = 1'b0;
    end
  endgenerate

  assign reject = too_long || (capacity < total);
endmodule

// File: rtl/vp8_out_stage.sv
module vp8_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              dlast,
  input  logic              out_ready,
  output logic              can_load,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (can_load) begin
      out_valid <= load;
      if (load) begin
        out_data <= din;
        out_last <= dlast;
      end
    end
  end
endmodule

// File: rtl/vp8_frame_asm.sv
module vp8_frame_asm
  import vp8_asm_pkg::*;
#(
  parameter int LEN_W = 24,
  localparam int CAP_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             key_frame,
  input  logic [LEN_W-1:0] hdr_len,
  input  logic [LEN_W-1:0] pay_len,
  input  logic [15:0]      pic_w,
  input  logic [15:0]      pic_h,
  input  logic [CAP_W-1:0] capacity,
  input  logic [7:0]       hdr_data,
  input  logic             hdr_valid,
  output logic             hdr_ready,
  input  logic [7:0]       pay_data,
  input  logic             pay_valid,
  output logic             pay_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  output logic             done,
  output logic [CAP_W-1:0] done_size,
  output logic             err
);
  asm_state_t        st;
  logic              key_q;
  logic [LEN_W-1:0]  hl_q, pl_q, cnt;
  logic [DIM_W-1:0]  w_q, h_q;
  logic [CAP_W-1:0]  cap_q, size_q;
  logic [PIDX_W-1:0] pidx;
  logic              err_q, done_q;

  logic [7:0]        pfx_byte;
  logic [PIDX_W-1:0] pfx_len;
  logic [CAP_W-1:0]  total;
  logic              reject;
  logic              can_load;
  logic              src_v, src_last, sec_end, fire;
  logic [7:0]        src_d;

  vp8_prefix_gen u_pfx (
    .first_len (hl_q[TAG_LEN_W-1:0]),
    .key       (key_q),
    .width     (w_q),
    .height    (h_q),
    .idx       (pidx),
    .pfx_byte  (pfx_byte),
    .pfx_len   (pfx_len)
  );

  vp8_size_check #(.LEN_W(LEN_W)) u_chk (
    .first_len (hl_q),
    .body_len  (pl_q),
    .pfx_len   (pfx_len),
    .capacity  (cap_q),
    .total     (total),
    .reject    (reject)
  );

  // source selection for the byte to load this cycle
  always_comb begin
    src_v    = 1'b0;
    src_d    = 8'h00;
    sec_end  = 1'b0;
    src_last = 1'b0;
    case (st)
      ST_PREFIX: begin
        src_v    = 1'b1;
        src_d    = pfx_byte;
        sec_end  = (pidx == pfx_len - 1'b1);
        src_last = sec_end && (hl_q == '0) && (pl_q == '0);
      end
      ST_HDR: begin
        src_v    = hdr_valid;
        src_d    = hdr_data;
        sec_end  = (cnt == hl_q - 1'b1);
        src_last = sec_end && (pl_q == '0);
      end
      ST_PAY: begin
        src_v    = pay_valid;
        src_d    = pay_data;
        sec_end  = (cnt == pl_q - 1'b1);
        src_last = sec_end;
      end
      default: ;
    endcase
  end

  assign fire      = src_v && can_load;
  assign hdr_ready = (st == ST_HDR) && can_load;
  assign pay_ready = (st == ST_PAY) && can_load;

  vp8_out_stage #(.DATA_W(8)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (fire),
    .din       (src_d),
    .dlast     (src_last),
    .out_ready (out_ready),
    .can_load  (can_load),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      key_q  <= 1'b0;
      hl_q   <= '0;
      pl_q   <= '0;
      w_q    <= '0;
      h_q    <= '0;
      cap_q  <= '0;
      size_q <= '0;
      cnt    <= '0;
      pidx   <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          key_q <= key_frame;
          hl_q  <= hdr_len;
          pl_q  <= pay_len;
          w_q   <= pic_w;
          h_q   <= pic_h;
          cap_q <= capacity;
          st    <= ST_CHECK;
        end
        ST_CHECK: begin
          size_q <= total;
          pidx   <= '0;
          cnt    <= '0;
          if (reject) begin
            err_q <= 1'b1;
            st    <= ST_IDLE;
          end else begin
            st <= ST_PREFIX;
          end
        end
        ST_PREFIX: if (fire) begin
          if (sec_end) begin
            if (src_last)        st <= ST_DRAIN;
            else if (hl_q != '0) st <= ST_HDR;
            else                 st <= ST_PAY;
          end else begin
            pidx <= pidx + 1'b1;
          end
        end
        ST_HDR: if (fire) begin
          if (sec_end) begin
            cnt <= '0;
            st  <= (pl_q != '0) ? ST_PAY : ST_DRAIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAY: if (fire) begin
          if (sec_end) st  <= ST_DRAIN;
          else         cnt <= cnt + 1'b1;
        end
        ST_DRAIN: if (out_valid && out_ready) begin
          done_q <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign err       = err_q;
  assign done_size = size_q;
endmodule

// File: rtl/vp8_frame_asm_chk.sv
module vp8_frame_asm_chk
  import vp8_asm_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       start,
  input asm_state_t st,
  input logic       hdr_ready,
  input logic       pay_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_last,
  input logic [7:0] out_data,
  input logic       done,
  input logic       err
);
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(hdr_ready && pay_ready)); // R9

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> (!hdr_ready && !pay_ready)); // R9

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R10

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready && out_last)); // R6

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    err |-> (!out_valid && !done && !hdr_ready && !pay_ready)); // R5

  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (start && (st == ST_PREFIX || st == ST_HDR || st == ST_PAY || st == ST_DRAIN))
      |=> (st != ST_CHECK)); // R8
endmodule

bind vp8_frame_asm vp8_frame_asm_chk u_chk_bind (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .st        (st),
  .hdr_ready (hdr_ready),
  .pay_ready (pay_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_data  (out_data),
  .done      (done),
  .err       (err)
);

// File: tb/vp8_frame_asm_tb.sv
module vp8_frame_asm_tb;
  localparam int LEN_W = 24;
  localparam int CAP_W = LEN_W + 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             key_frame = 1'b0;
  logic [LEN_W-1:0] hdr_len = '0, pay_len = '0;
  logic [15:0]      pic_w = '0, pic_h = '0;
  logic [CAP_W-1:0] capacity = '0;
  logic [7:0]       hdr_data = '0, pay_data = '0;
  logic             hdr_valid = 1'b0, pay_valid = 1'b0, out_ready = 1'b1;
  logic             hdr_ready, pay_ready, out_valid, out_last, done, err;
  logic [7:0]       out_data;
  logic [CAP_W-1:0] done_size;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  vp8_frame_asm #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .key_frame(key_frame),
    .hdr_len(hdr_len), .pay_len(pay_len), .pic_w(pic_w), .pic_h(pic_h),
    .capacity(capacity), .hdr_data(hdr_data), .hdr_valid(hdr_valid),
    .hdr_ready(hdr_ready), .pay_data(pay_data), .pay_valid(pay_valid),
    .pay_ready(pay_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_last(out_last), .done(done),
    .done_size(done_size), .err(err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input bit key, input int hl, input int pl,
                           input int cap, input bit mode, input bit exp_err);
    logic [7:0] exp_b [0:63];
    int  plen, total, ob, hi, pi, mism;
    bit  got_done, got_err, prev_last, late_done;
    logic [23:0] tag;
    logic [15:0] w, h;
    w     = 16'h0140 + 16'(hl * 3);
    h     = 16'h00F0 + 16'(pl * 257);
    plen  = key ? 10 : 3;
    total = plen + hl + pl;
    tag   = 24'((hl << 5) | 16 | (key ? 0 : 1));
    if (!exp_err) begin
      exp_b[0] = tag[7:0]; exp_b[1] = tag[15:8]; exp_b[2] = tag[23:16];
      if (key) begin
        exp_b[3] = 8'h9D; exp_b[4] = 8'h01; exp_b[5] = 8'h2A;
        exp_b[6] = w[7:0]; exp_b[7] = w[15:8]; exp_b[8] = h[7:0]; exp_b[9] = h[15:8];
      end
      for (int i = 0; i < hl; i++) exp_b[plen + i] = 8'(8'hA0 + i);
      for (int i = 0; i < pl; i++) exp_b[plen + hl + i] = 8'(8'h30 + i);
    end
    @(negedge clk);
    start = 1'b1; key_frame = key; hdr_len = LEN_W'(hl); pay_len = LEN_W'(pl);
    pic_w = w; pic_h = h; capacity = CAP_W'(cap);
    ob = 0; hi = 0; pi = 0; mism = 0;
    got_done = 0; got_err = 0; prev_last = 0; late_done = 0;
    for (int it = 0; it < 500; it++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      // R8: spurious start with different fields while the frame runs
      start = (it == 1) && !exp_err;
      key_frame = (it == 1) ? ~key : key;
      hdr_len   = (it == 1) ? '0 : LEN_W'(hl);
      pay_len   = (it == 1) ? LEN_W'(1) : LEN_W'(pl);
      out_ready = mode ? (lfsr[0] | lfsr[3]) : 1'b1;
      hdr_valid = (hi < hl) && (mode ? (lfsr[5] | lfsr[7]) : 1'b1);
      pay_valid = (pi < pl) && (mode ? (lfsr[9] | lfsr[2]) : 1'b1);
      hdr_data  = 8'(8'hA0 + hi);
      pay_data  = 8'(8'h30 + pi);
      #1;
      if (done) begin
        got_done = 1;
        late_done = !prev_last;
        break;
      end
      if (err) begin
        got_err = 1;
        check(it == 1, "R5 err timing", it, 1);
        break;
      end
      if (out_valid && out_ready) begin
        if (ob < total && !exp_err) begin
          if (out_data !== exp_b[ob]) mism++;
          check(out_data === exp_b[ob], ob < 3 ? "R1 tag byte" : (ob < plen ? "R2 key prefix" : "R4 section data"),
                out_data, exp_b[ob]);
          check(out_last === (ob == total - 1), "R7 last marker", out_last, ob == total - 1);
        end else begin
          check(0, "R4 extra byte", ob, total);
        end
        ob++;
        prev_last = out_last;
      end else begin
        prev_last = 0;
      end
      if (hdr_valid && hdr_ready) hi++;
      if (pay_valid && pay_ready) pi++;
    end
    start = 1'b0; hdr_valid = 1'b0; pay_valid = 1'b0; out_ready = 1'b1;
    if (exp_err) begin
      check(got_err, "R5 err pulse", got_err, 1);
      check(ob == 0 && hi == 0 && pi == 0, "R5 nothing moved", ob + hi + pi, 0);
      @(negedge clk); #1;
      check(!err && !out_valid, "R5 single err pulse", err, 0);
    end else begin
      check(got_done, "R6 done seen", got_done, 1);
      check(!late_done, "R6 done one cycle after last", late_done, 0);
      check(done_size == CAP_W'(total), "R6 done_size", done_size, total);
      check(ob == total && hi == hl && pi == pl, mode ? "R10 byte count under stalls" : "R4 byte count",
            ob, total);
      check(mism == 0, "R8 stream unaffected by busy start", mism, 0);
      if (!key) check(ob == 3 + hl + pl, "R3 inter prefix length", ob, 3 + hl + pl);
      if (cap == total) check(got_done, "R5 exact capacity accepted", got_done, 1);
      @(negedge clk); #1;
      check(!done && !out_valid, "R6 single done pulse", done, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid && !done && !err, "R6 reset outputs", {out_valid, done, err}, 0);
    check(!hdr_ready && !pay_ready, "R9 no ready when idle", {hdr_ready, pay_ready}, 0);
    for (int m = 0; m < 2; m++)
      for (int k = 0; k < 2; k++)
        for (int hl = 0; hl < 5; hl++)
          for (int pl = 0; pl < 4; pl++) begin
            int tot;
            tot = (k ? 10 : 3) + hl + pl;
            run_frame(k[0], hl, pl, tot, m[0], 1'b0);
            run_frame(k[0], hl, pl, tot - 1, m[0], 1'b0 | 1'b1);
          end
    // wider tag field value and roomy buffer
    run_frame(1'b1, 37, 5, 1000, 1'b1, 1'b0);
    run_frame(1'b0, 37, 0, 40, 1'b0, 1'b0);
    // R11: first-partition length beyond the 19-bit tag field
    run_frame(1'b0, 1 << 19, 0, 1 << 22, 1'b0, 1'b1);
    run_frame(1'b1, (1 << 19) + 3, 2, 1 << 22, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule